// File: doc/BRIEF.md
# Multi-Format Pixel Input Capture

This block sits on the parallel pixel input of a video encoder that runs with flicker filtering enabled. One pixel arrives on every rising edge of the double-rate clock `clk2`. A run-time format select picks one of three layouts for the input bus:

- 16-bit 4:2:2 YCbCr: luma on the upper byte, and alternating Cb/Cr chroma on the lower byte.
- 16-bit RGB in 5-6-5 packing.
- 24-bit RGB.

The block turns every layout into one uniform per-pixel word with three full 8-bit components. It carries the overlay bits, the mode bits and the three timing signals (blank, horizontal sync, vertical sync) alongside the word, with the same delay. It also drives an optional half-rate clock output.

In the 4:2:2 layout an even pixel and the odd pixel after it share one Cb/Cr pair. The Cr of that pair arrives one clock after the even pixel. For this reason the block holds a fixed three-cycle latency from the sampling edge to the output in every format. The output stream has a valid flag (`pix_valid`, high for active pixels) and no ready input. The video timing cannot be stalled, so there is no back-pressure: the consumer must take a word on every `clk2` cycle in which `pix_valid` is high.

Top module: `pxc_input_capture`

## Requirements
- R1: `pix_in`, `ovl_in`, `mode_in`, `blank_in`, `hsync_in` and `vsync_in` are sampled on every rising `clk2` edge. A sample taken at edge n appears on the outputs just after edge n+2, so it is visible during the cycle that follows.
- R2: In format 0 (YCbCr), `comp0_out` is Y taken from `pix_in[15:8]`. The lower byte `pix_in[7:0]` carries Cb on even pixels and Cr on odd pixels. Both pixels of a pair output that pair's Cb on `comp1_out` and its Cr on `comp2_out`.
- R3: The chroma phase restarts on every line. The first pixel with `blank_in` low after a blanked cycle is an even (Cb) pixel.
- R4: In format 1 (RGB 5-6-5), R = `pix_in[15:11]`, G = `pix_in[10:5]` and B = `pix_in[4:0]`. Each component is widened to 8 bits by appending its own top bits below it. `pix_in[23:16]` is ignored.
- R5: In format 2, and in code 3 which behaves the same, R = `pix_in[23:16]`, G = `pix_in[15:8]` and B = `pix_in[7:0]`. They appear on `comp0_out`, `comp1_out` and `comp2_out` in that order.
- R6: `ovl_out` and `mode_out` carry the overlay and mode bits sampled with the same pixel, with the same latency as the pixel word.
- R7: `blank_out`, `hsync_out` and `vsync_out` follow their inputs with the R1 latency. `pix_valid` is high exactly when `blank_out` is low.
- R8: While `clk_out_en` is high at an edge, `clk_out` inverts on that edge, giving half the `clk2` rate. While it is low, `clk_out` goes to 0 and stays there.
- R9: A synchronous reset (`rst` high at an edge) sets `blank_out` to 1 and `pix_valid`, `hsync_out`, `vsync_out`, the component outputs and `clk_out` to 0.
- R10: `fmt_sel` may change only in cycles where `blank_in` is high, or where it was high on the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2 | input | 1 | Double-rate pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 2 | 0 YCbCr 4:2:2, 1 RGB 5-6-5, 2/3 RGB 8-8-8 |
| pix_in | input | PIX_W (24) | Parallel pixel bus |
| ovl_in | input | 3 | Overlay select bits |
| mode_in | input | 2 | Per-pixel mode bits |
| blank_in | input | 1 | Blanking input, high = blanked |
| hsync_in | input | 1 | Horizontal sync input |
| vsync_in | input | 1 | Vertical sync input |
| clk_out_en | input | 1 | Enables the half-rate clock output |
| pix_valid | output | 1 | Output word holds an active pixel |
| comp0_out | output | 8 | Y or R |
| comp1_out | output | 8 | Cb or G |
| comp2_out | output | 8 | Cr or B |
| ovl_out | output | 3 | Overlay bits, delayed |
| mode_out | output | 2 | Mode bits, delayed |
| blank_out | output | 1 | Blanking, delayed |
| hsync_out | output | 1 | Horizontal sync, delayed |
| vsync_out | output | 1 | Vertical sync, delayed |
| clk_out | output | 1 | Half-rate clock |

## Verification
A wrong chroma phase shows up within one line at most. The first pixel after blanking would carry a Cr value as its Cb, and the two pixels of a pair would show different chroma. A stage that is missing or doubled moves the sync and blank outputs by a cycle relative to the pixel word, and this is visible three edges after any sync edge. A stuck or mis-reset divider shows on `clk_out` within two edges.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  localparam int COMP_W = 8;
  localparam int OVL_W  = 3;
  localparam int MODE_W = 2;
  localparam int CH_W   = 3 * COMP_W;

  typedef enum logic [1:0] {
    FMT_YCC16 = 2'd0,
    FMT_RGB16 = 2'd1,
    FMT_RGB24 = 2'd2,
    FMT_RGB24_ALT = 2'd3
  } fmt_e;

  typedef struct packed {
    logic              blank;
    logic              hs;
    logic              vs;
    logic [OVL_W-1:0]  ovl;
    logic [MODE_W-1:0] mode;
  } side_t;

  localparam side_t SIDE_IDLE = '{blank: 1'b1, hs: 1'b0, vs: 1'b0, ovl: '0, mode: '0};

  // widen a 5-bit field to 8 bits by replicating its upper bits
  function automatic logic [COMP_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [COMP_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction
endpackage

// File: rtl/pxc_capture.sv
module pxc_capture
  import pxc_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk2,
  input  logic             rst,
  input  logic [1:0]       fmt_sel,
  input  logic [PIX_W-1:0] pix_in,
  input  side_t            side_in,
  output logic [PIX_W-1:0] s1_pix,
  output side_t            s1_side,
  output logic             s1_odd,
  output fmt_e             s1_fmt
);
  logic phase_q;

  always_ff @(posedge clk2) begin
    if (rst) begin
      phase_q <= 1'b0;
      s1_pix  <= '0;
      s1_side <= SIDE_IDLE;
      s1_odd  <= 1'b0;
      s1_fmt  <= FMT_YCC16;
    end else begin
      s1_pix  <= pix_in;
      s1_side <= side_in;
      s1_fmt  <= fmt_e'(fmt_sel);
      if (side_in.blank) begin
        phase_q <= 1'b0;
        s1_odd  <= 1'b0;
      end else begin
        phase_q <= ~phase_q;
        s1_odd  <= phase_q;
      end
    end
  end

  // R10
  fmt_quiet_chk: assert property (@(posedge clk2) disable iff (rst)
    (!side_in.blank && !$past(side_in.blank)) |-> $stable(fmt_sel));
endmodule

// File: rtl/pxc_unpack.sv
module pxc_unpack
  import pxc_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              clk2,
  input  logic              rst,
  input  logic [PIX_W-1:0]  s1_pix,
  input  side_t             s1_side,
  input  logic              s1_odd,
  input  fmt_e              s1_fmt,
  output logic [COMP_W-1:0] c0_q,
  output logic [COMP_W-1:0] c1_q,
  output logic [COMP_W-1:0] c2_q,
  output side_t             side_q,
  output logic              valid_q
);
  logic [PIX_W-1:0]  s2_pix;
  side_t             s2_side;
  logic              s2_odd;
  fmt_e              s2_fmt;
  logic [COMP_W-1:0] cb_hold;
  logic [COMP_W-1:0] c0_d, c1_d, c2_d;
  logic              odd_q;
  fmt_e              fmt_q;

  always_ff @(posedge clk2) begin
    if (rst) begin
      s2_pix  <= '0;
      s2_side <= SIDE_IDLE;
      s2_odd  <= 1'b0;
      s2_fmt  <= FMT_YCC16;
      cb_hold <= '0;
    end else begin
      s2_pix  <= s1_pix;
      s2_side <= s1_side;
      s2_odd  <= s1_odd;
      s2_fmt  <= s1_fmt;
      if (!s2_odd) cb_hold <= s2_pix[COMP_W-1:0];
    end
  end

  always_comb begin
    c0_d = '0;
    c1_d = '0;
    c2_d = '0;
    unique case (s2_fmt)
      FMT_YCC16: begin
        c0_d = s2_pix[2*COMP_W-1:COMP_W];
        if (!s2_odd) begin
          c1_d = s2_pix[COMP_W-1:0];
          c2_d = s1_pix[COMP_W-1:0];
        end else begin
          c1_d = cb_hold;
          c2_d = s2_pix[COMP_W-1:0];
        end
      end
      FMT_RGB16: begin
        c0_d = widen5(s2_pix[15:11]);
        c1_d = widen6(s2_pix[10:5]);
        c2_d = widen5(s2_pix[4:0]);
      end
      FMT_RGB24, FMT_RGB24_ALT: begin
        c0_d = s2_pix[3*COMP_W-1:2*COMP_W];
        c1_d = s2_pix[2*COMP_W-1:COMP_W];
        c2_d = s2_pix[COMP_W-1:0];
      end
    endcase
  end

  always_ff @(posedge clk2) begin
    if (rst) begin
      c0_q    <= '0;
      c1_q    <= '0;
      c2_q    <= '0;
      side_q  <= SIDE_IDLE;
      valid_q <= 1'b0;
      odd_q   <= 1'b0;
      fmt_q   <= FMT_YCC16;
    end else begin
      c0_q    <= c0_d;
      c1_q    <= c1_d;
      c2_q    <= c2_d;
      side_q  <= s2_side;
      valid_q <= !s2_side.blank;
      odd_q   <= s2_odd;
      fmt_q   <= s2_fmt;
    end
  end

  // R2
  pair_chroma_chk: assert property (@(posedge clk2) disable iff (rst)
    (valid_q && odd_q && fmt_q == FMT_YCC16 && $past(valid_q))
      |-> (c1_q == $past(c1_q) && c2_q == $past(c2_q)));

  // R3
  line_phase_chk: assert property (@(posedge clk2) disable iff (rst)
    $rose(valid_q) |-> !odd_q);
endmodule

// File: rtl/pxc_clkdiv.sv
module pxc_clkdiv (
  input  logic clk2,
  input  logic rst,
  input  logic en,
  output logic half_clk
);
  always_ff @(posedge clk2) begin
    if (rst || !en) half_clk <= 1'b0;
    else            half_clk <= ~half_clk;
  end

  // R8
  half_toggle_chk: assert property (@(posedge clk2) disable iff (rst)
    en |=> (half_clk != $past(half_clk)));

  // R8
  half_idle_chk: assert property (@(posedge clk2) disable iff (rst)
    !en |=> !half_clk);
endmodule

// File: rtl/pxc_input_capture.sv
module pxc_input_capture
  import pxc_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic              clk2,
  input  logic              rst,
  input  logic [1:0]        fmt_sel,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic [OVL_W-1:0]  ovl_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              blank_in,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              clk_out_en,
  output logic              pix_valid,
  output logic [COMP_W-1:0] comp0_out,
  output logic [COMP_W-1:0] comp1_out,
  output logic [COMP_W-1:0] comp2_out,
  output logic [OVL_W-1:0]  ovl_out,
  output logic [MODE_W-1:0] mode_out,
  output logic              blank_out,
  output logic              hsync_out,
  output logic              vsync_out,
  output logic              clk_out
);
  localparam int DEPTH = 3;

  side_t            side_in, s1_side, side_q;
  logic [PIX_W-1:0] s1_pix;
  logic             s1_odd;
  fmt_e             s1_fmt;

  assign side_in = '{blank: blank_in, hs: hsync_in, vs: vsync_in, ovl: ovl_in, mode: mode_in};

  pxc_capture #(.PIX_W(PIX_W)) u_cap (
    .clk2(clk2), .rst(rst), .fmt_sel(fmt_sel), .pix_in(pix_in), .side_in(side_in),
    .s1_pix(s1_pix), .s1_side(s1_side), .s1_odd(s1_odd), .s1_fmt(s1_fmt)
  );

  pxc_unpack #(.PIX_W(PIX_W)) u_unp (
    .clk2(clk2), .rst(rst), .s1_pix(s1_pix), .s1_side(s1_side), .s1_odd(s1_odd),
    .s1_fmt(s1_fmt), .c0_q(comp0_out), .c1_q(comp1_out), .c2_q(comp2_out),
    .side_q(side_q), .valid_q(pix_valid)
  );

  pxc_clkdiv u_div (
    .clk2(clk2), .rst(rst), .en(clk_out_en), .half_clk(clk_out)
  );

  assign ovl_out   = side_q.ovl;
  assign mode_out  = side_q.mode;
  assign blank_out = side_q.blank;
  assign hsync_out = side_q.hs;
  assign vsync_out = side_q.vs;

  // edges since reset, saturating at the pipeline depth
  logic [1:0] warm_q;
  always_ff @(posedge clk2) begin
    if (rst) warm_q <= '0;
    else if (warm_q != 2'(DEPTH)) warm_q <= warm_q + 2'd1;
  end

  // R7
  sync_delay_chk: assert property (@(posedge clk2) disable iff (rst)
    (warm_q == 2'(DEPTH)) |-> (blank_out == $past(blank_in, 3) &&
      hsync_out == $past(hsync_in, 3) && vsync_out == $past(vsync_in, 3)));

  // R6
  ovl_delay_chk: assert property (@(posedge clk2) disable iff (rst)
    (warm_q == 2'(DEPTH)) |-> (ovl_out == $past(ovl_in, 3) && mode_out == $past(mode_in, 3)));
endmodule

// File: tb/pxc_input_capture_tb.sv
module pxc_input_capture_tb_top;
  logic clk2 = 1'b0;
  always #5 clk2 = ~clk2;

  logic        rst, blank_in, hsync_in, vsync_in, clk_out_en;
  logic [1:0]  fmt_sel, mode_in;
  logic [23:0] pix_in;
  logic [2:0]  ovl_in;
  logic        pix_valid, blank_out, hsync_out, vsync_out, clk_out;
  logic [7:0]  comp0_out, comp1_out, comp2_out;
  logic [2:0]  ovl_out;
  logic [1:0]  mode_out;

  pxc_input_capture dut_i (
    .clk2(clk2), .rst(rst), .fmt_sel(fmt_sel), .pix_in(pix_in), .ovl_in(ovl_in),
    .mode_in(mode_in), .blank_in(blank_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .clk_out_en(clk_out_en), .pix_valid(pix_valid), .comp0_out(comp0_out),
    .comp1_out(comp1_out), .comp2_out(comp2_out), .ovl_out(ovl_out), .mode_out(mode_out),
    .blank_out(blank_out), .hsync_out(hsync_out), .vsync_out(vsync_out), .clk_out(clk_out)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // {fmt[54:53], pix[52:29], ovl[28:26], mode[25:24], expected RGB[23:0]}
  localparam int NV = 8;
  localparam logic [54:0] VEC [NV] = '{
    {2'd1, 24'h00F800, 3'd1, 2'd0, 24'hFF0000},
    {2'd1, 24'h0007E0, 3'd2, 2'd1, 24'h00FF00},
    {2'd1, 24'h00001F, 3'd3, 2'd2, 24'h0000FF},
    {2'd1, 24'h008410, 3'd4, 2'd3, 24'h848284},
    {2'd1, 24'hFF0000, 3'd5, 2'd1, 24'h000000},
    {2'd2, 24'h123456, 3'd6, 2'd2, 24'h123456},
    {2'd3, 24'hABCDEF, 3'd7, 2'd3, 24'hABCDEF},
    {2'd2, 24'hFFFFFF, 3'd0, 2'd0, 24'hFFFFFF}
  };

  // YCbCr stream: per step blank, hsync, vsync, Y, chroma byte
  localparam int NS = 12;
  localparam logic [NS-1:0] S_BLANK = 12'b1111_1001_0001;  // bit j = step j
  localparam logic [NS-1:0] S_HS    = 12'b0000_0001_0000;
  localparam logic [NS-1:0] S_VS    = 12'b0001_0000_0000;
  localparam logic [7:0] S_Y [NS] = '{8'h00, 8'h20, 8'h21, 8'h22, 8'h00, 8'h30, 8'h31,
                                      8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [7:0] S_C [NS] = '{8'h00, 8'h40, 8'h50, 8'h42, 8'h99, 8'h60, 8'h70,
                                      8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [7:0] E_CB [NS] = '{8'h00, 8'h40, 8'h40, 8'h42, 8'h00, 8'h60, 8'h60,
                                       8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [7:0] E_CR [NS] = '{8'h00, 8'h50, 8'h50, 8'h00, 8'h00, 8'h70, 8'h70,
                                       8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [NS-1:0] E_CRCHK = 12'b0000_0110_0110;

  initial begin
    repeat (20000) @(posedge clk2);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic prev;
    rst = 1; blank_in = 1; hsync_in = 0; vsync_in = 0; clk_out_en = 0;
    fmt_sel = 2'd0; mode_in = 0; pix_in = 0; ovl_in = 0;
    repeat (2) @(posedge clk2);
    @(negedge clk2);
    // R9 reset state
    chk("R9 blank_out", blank_out, 1);
    chk("R9 pix_valid", pix_valid, 0);
    chk("R9 comps", {comp0_out, comp1_out, comp2_out}, 0);
    chk("R9 syncs", {hsync_out, vsync_out}, 0);
    chk("R9 clk_out", clk_out, 0);
    rst = 0;

    // RGB table, R4 R5 R6 R1
    for (int i = 0; i < NV; i++) begin
      blank_in = 1; fmt_sel = VEC[i][54:53];
      @(negedge clk2);
      blank_in = 0; pix_in = VEC[i][52:29]; ovl_in = VEC[i][28:26]; mode_in = VEC[i][25:24];
      repeat (3) @(posedge clk2);
      @(negedge clk2);
      chk(VEC[i][54:53] == 2'd1 ? "R4 rgb565 word" : "R5 rgb888 word",
          {comp0_out, comp1_out, comp2_out}, VEC[i][23:0]);
      chk("R6 overlay/mode", {ovl_out, mode_out}, {VEC[i][28:26], VEC[i][25:24]});
      chk("R7 pix_valid active", pix_valid, 1);
      blank_in = 1;
    end

    // YCbCr stream with line restart, R2 R3 R7 R1
    @(negedge clk2);
    fmt_sel = 2'd0; ovl_in = 0; mode_in = 0;
    for (int j = 0; j < NS + 3; j++) begin
      if (j >= 3) begin
        chk("R7 blank_out", blank_out, S_BLANK[j-3]);
        chk("R7 pix_valid", pix_valid, !S_BLANK[j-3]);
        chk("R7 hsync_out", hsync_out, S_HS[j-3]);
        chk("R7 vsync_out", vsync_out, S_VS[j-3]);
        if (!S_BLANK[j-3]) begin
          chk("R2 luma", comp0_out, S_Y[j-3]);
          chk("R2 R3 Cb", comp1_out, E_CB[j-3]);
          if (E_CRCHK[j-3]) chk("R2 R3 Cr", comp2_out, E_CR[j-3]);
        end
      end
      if (j < NS) begin
        blank_in = S_BLANK[j]; hsync_in = S_HS[j]; vsync_in = S_VS[j];
        pix_in = {8'h00, S_Y[j], S_C[j]};
      end else begin
        blank_in = 1; hsync_in = 0; vsync_in = 0; pix_in = 0;
      end
      @(negedge clk2);
    end

    // half-rate clock, R8
    clk_out_en = 1;
    @(negedge clk2);
    prev = clk_out;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk2);
      chk("R8 clk_out toggles", clk_out, !prev);
      prev = clk_out;
    end
    clk_out_en = 0;
    @(negedge clk2);
    chk("R8 clk_out idle", clk_out, 0);
    @(negedge clk2);
    chk("R8 clk_out stays idle", clk_out, 0);

    // mid-stream reset, R9
    clk_out_en = 1; fmt_sel = 2'd2; blank_in = 1;
    @(negedge clk2);
    blank_in = 0; pix_in = 24'h5A5A5A; hsync_in = 1;
    repeat (3) @(negedge clk2);
    chk("R9 pre-reset active", pix_valid, 1);
    rst = 1;
    @(negedge clk2);
    chk("R9 mid reset blank", blank_out, 1);
    chk("R9 mid reset valid", pix_valid, 0);
    chk("R9 mid reset data", {comp0_out, comp1_out, comp2_out, hsync_out}, 0);
    chk("R9 mid reset clk_out", clk_out, 0);
    rst = 0; blank_in = 1; hsync_in = 0;
    repeat (4) @(negedge clk2);
    finish_run();
  end
endmodule